// File: doc/BRIEF.md
# Eight-bit Event Timer with Programmable Prescaler

This block is an 8-bit up-counter for a small microcontroller. It counts one of two event sources. The first is the instruction cycle, which the block derives from the system (oscillator) clock as one tick every 2 or 4 clocks. The second is a chosen edge of an external pin. A prescaler can sit in front of the counter and divide the events by a power of two from 2 to 256. A bypass bit lets every event reach the counter directly.

Software loads the counter through a write port, and every such load also empties the prescaler. A separate control register holds the division ratio, the source select, the edge select and the bypass bit. When the counter rolls over from its top value to zero it sets a sticky overflow flag. That flag, qualified by a local enable and a global enable, forms the interrupt request.

Top module: `evt_timer8`

## Requirements
- R1: After reset the counter reads 0x00, the control readback reads 0x00, and both the overflow flag and the interrupt request are low.
- R2: A counter write loads the written value at the next clock edge. On that edge the write wins over any increment, so the value read right after the write equals the data written.
- R3: A counter write clears the prescaler, so the next increment needs a full prescale ratio of events counted after the write. Events gathered before the write are lost.
- R4: With the internal source and the bypass bit set, the counter advances once per instruction cycle. The instruction cycle is 2 clocks when `cyc_div4` is 0 and 4 clocks when it is 1, and the counter never advances on two consecutive clocks.
- R5: With the bypass bit clear, a ratio field value n (0 to 7) divides the events by 2^(n+1), from 1:2 up to 1:256.
- R6: With the external source, the counter counts rising edges of `ext_pin` when the edge bit is 0 and falling edges when it is 1. Edges of the other polarity are not counted. The pin passes through a two-flop synchroniser, so a bypassed pin edge driven before clock edge 1 shows on `count` after clock edge 3 and not after clock edge 2.
- R7: An increment from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr` high clears it, and a wrap in the same cycle wins over the clear. A counter write never sets the flag.
- R8: `irq` is high exactly when `ovf_flag`, `irq_en` and `glb_en` are all high.
- R9: A control write loads `ctl_wr_data` at the next edge, and `ctl_rd` reads it back. The fields are ratio in bits [2:0], source select in bit 3 (1 = external pin), edge select in bit 4 (1 = falling) and prescaler bypass in bit 5 (1 = bypass).
- R10: The source not selected by bit 3 has no effect. The pin does not move the counter in internal mode, and instruction ticks do not move it in external mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_div4 | input | 1 | Instruction cycle length: 0 = 2 clocks, 1 = 4 clocks |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | 8 | Counter write value |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 6 | Control register write value |
| ext_pin | input | 1 | Asynchronous external count input |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Local enable for the overflow interrupt |
| glb_en | input | 1 | Global interrupt enable |
| count | output | 8 | Current counter value |
| ctl_rd | output | 6 | Control register readback |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check, on every cycle, the load-on-write rule and the prescaler clear that comes with it. They also check that the counter only holds or steps by one, that a rollover always sets the flag, that the flag never sets without a rollover and never drops without a clear, and the minimum spacing of bypassed internal increments. The exact division ratios and the two instruction-cycle lengths can only be shown by the bench's scenarios. The same holds for edge polarity, synchroniser latency, and the loss of a partial prescale count on a write, since each of these needs a counted window of events.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int TMR_RSEL_W = 3;

    // Control register layout, MSB first: bypass, edge, source, ratio
    typedef struct packed {
        logic                  bypass;
        logic                  edge_fall;
        logic                  src_ext;
        logic [TMR_RSEL_W-1:0] ratio;
    } tmr_ctl_t;

    localparam int TMR_CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr8_tick_gen.sv
module tmr8_tick_gen #(
    parameter int PH_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div4,
    output logic tick
);
    logic [PH_W-1:0] ph_d, ph_q;
    logic [PH_W-1:0] last_ph;

    always_comb begin
        last_ph = div4 ? PH_W'(3) : PH_W'(1);
        tick    = (ph_q == last_ph);
        ph_d    = (ph_q >= last_ph) ? '0 : ph_q + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/tmr8_pin_edge.sv
module tmr8_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;
    logic            cur, prev;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin};
        cur  = sh_q[SH_W-2];
        prev = sh_q[SH_W-1];
        evt  = fall_sel ? (prev & ~cur) : (cur & ~prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
    parameter int PSC_W  = 8,
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              clr,
    input  logic              bypass,
    input  logic [RSEL_W-1:0] ratio,
    output logic              evt_out,
    output logic [PSC_W-1:0]  psc_cnt
);
    logic [PSC_W-1:0] psc_d, psc_q;
    logic [PSC_W:0]   lim_m1;
    logic             at_end;

    always_comb begin
        lim_m1  = ((PSC_W+1)'(2) << ratio) - (PSC_W+1)'(1);
        at_end  = ({1'b0, psc_q} >= lim_m1);
        evt_out = evt_in & (bypass | at_end);
        psc_d   = psc_q;
        if (clr)                 psc_d = '0;
        else if (evt_in && !bypass) psc_d = at_end ? '0 : psc_q + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    assign psc_cnt = psc_q;
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_div4,
    input  logic                 cnt_wr_en,
    input  logic [CNT_W-1:0]     cnt_wr_data,
    input  logic                 ctl_wr_en,
    input  logic [TMR_CTL_W-1:0] ctl_wr_data,
    input  logic                 ext_pin,
    input  logic                 ovf_clr,
    input  logic                 irq_en,
    input  logic                 glb_en,
    output logic [CNT_W-1:0]     count,
    output logic [TMR_CTL_W-1:0] ctl_rd,
    output logic                 ovf_flag,
    output logic                 irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        tmr_ctl_t         ctl;
        logic             ovf;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic             tick, pin_evt, raw_evt, cnt_evt, wrap;
    logic [PSC_W-1:0] psc_cnt;

    tmr8_tick_gen #(.PH_W(2)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div4 (cyc_div4),
        .tick (tick)
    );

    tmr8_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (ext_pin),
        .fall_sel(st_q.ctl.edge_fall),
        .evt     (pin_evt)
    );

    assign raw_evt = st_q.ctl.src_ext ? pin_evt : tick;

    tmr8_prescaler #(.PSC_W(PSC_W), .RSEL_W(TMR_RSEL_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (raw_evt),
        .clr    (cnt_wr_en),
        .bypass (st_q.ctl.bypass),
        .ratio  (st_q.ctl.ratio),
        .evt_out(cnt_evt),
        .psc_cnt(psc_cnt)
    );

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (ctl_wr_en) st_d.ctl = tmr_ctl_t'(ctl_wr_data);
        if (cnt_wr_en) begin
            st_d.cnt = cnt_wr_data;
        end else if (cnt_evt) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            wrap     = (st_q.cnt == '1);
        end
        if (wrap)         st_d.ovf = 1'b1;
        else if (ovf_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign ctl_rd   = st_q.ctl;
    assign ovf_flag = st_q.ovf;
    assign irq      = st_q.ovf & irq_en & glb_en;
endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 8,
    parameter int CTL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic [CNT_W-1:0] count,
    input logic [CTL_W-1:0] ctl_rd,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic             irq,
    input logic [PSC_W-1:0] psc_cnt
);
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> count == $past(cnt_wr_data));

    assert_psc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> psc_cnt == '0);

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_en |=> (count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1))));

    // R4: bypassed internal increments are at least two clocks apart
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr_en) && count != $past(count) && $stable(ctl_rd)
         && ctl_rd[5] && !ctl_rd[3] && !cnt_wr_en) |=> $stable(count));

    assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && $past(count) == '1 && !$past(cnt_wr_en)) |-> ovf_flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_flag |=> (!ovf_flag || count == '0));

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);
endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .CTL_W(tmr8_pkg::TMR_CTL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr_en  (cnt_wr_en),
    .cnt_wr_data(cnt_wr_data),
    .count      (count),
    .ctl_rd     (ctl_rd),
    .ovf_flag   (ovf_flag),
    .ovf_clr    (ovf_clr),
    .irq        (irq),
    .psc_cnt    (psc_cnt)
);

// File: tb/tb_evt_timer8.sv
`timescale 1ns/1ps
module tb_evt_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_div4 = 1'b0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = '0;
    logic       ctl_wr_en = 1'b0;
    logic [5:0] ctl_wr_data = '0;
    logic       ext_pin = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       glb_en = 1'b0;
    logic [7:0] count;
    logic [5:0] ctl_rd;
    logic       ovf_flag;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer8 dut (
        .clk(clk), .rst_n(rst_n), .cyc_div4(cyc_div4),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ext_pin(ext_pin), .ovf_clr(ovf_clr), .irq_en(irq_en), .glb_en(glb_en),
        .count(count), .ctl_rd(ctl_rd), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    // bypass, falling edge, external source, ratio
    task automatic wr_ctl(input bit by, input bit fall, input bit ext, input int r);
        ctl_wr_en = 1'b1; ctl_wr_data = {by, fall, ext, 3'(r)};
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic pulse();
        ext_pin = 1'b1; clk_n(4);
        ext_pin = 1'b0; clk_n(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clk_n(3);
        rst_n = 1'b1;
        clk_n(1);
        // R1 reset state
        chk(count == 8'h00, "R1 count", count, 0);
        chk(ctl_rd == 6'h00, "R1 ctl", ctl_rd, 0);
        chk(!ovf_flag && !irq, "R1 flag/irq", {ovf_flag, irq}, 0);

        // R9 control readback
        wr_ctl(1, 0, 1, 5);
        chk(ctl_rd == 6'h2D, "R9 ctl readback", ctl_rd, 6'h2D);

        // R2 write priority while ticking every 2 clocks
        cyc_div4 = 1'b0;
        wr_ctl(1, 0, 0, 0);
        clk_n(3);
        wr_cnt(8'h77);
        chk(count == 8'h77, "R2 load", count, 8'h77);
        wr_cnt(8'h55);
        chk(count == 8'h55, "R2 load", count, 8'h55);

        // R4/R5 internal sweep over cycle length, bypass and ratio
        for (int d = 0; d < 2; d++) begin
            for (int by = 0; by < 2; by++) begin
                for (int r = 0; r < 8; r++) begin
                    if (by == 1 && r > 0) continue;
                    cyc_div4 = 1'(d);
                    wr_ctl(1'(by), 0, 0, r);
                    clk_n(4);
                    wr_cnt(8'h10);
                    clk_n((d ? 4 : 2) * (by ? 1 : (2 << r)) * 3);
                    chk(count == 8'h13, by ? "R4 internal rate" : "R5 internal ratio", count, 8'h13);
                end
            end
        end

        // R10 pin ignored in internal mode
        cyc_div4 = 1'b0;
        wr_ctl(1, 0, 0, 0);
        clk_n(4);
        wr_cnt(8'h00);
        for (int i = 0; i < 20; i++) begin
            ext_pin = ~ext_pin;
            clk_n(2);
        end
        chk(count == 8'd20, "R10 pin ignored", count, 20);
        ext_pin = 1'b0;

        // R6 external rising edges
        wr_ctl(1, 0, 1, 0);
        clk_n(4);
        wr_cnt(8'h00);
        for (int i = 0; i < 5; i++) pulse();
        chk(count == 8'd5, "R6 rising count", count, 5);
        ext_pin = 1'b1;
        clk_n(2);
        chk(count == 8'd5, "R6 latency early", count, 5);
        clk_n(1);
        chk(count == 8'd6, "R6 latency edge3", count, 6);
        ext_pin = 1'b0;
        clk_n(4);
        chk(count == 8'd6, "R6 falling ignored", count, 6);

        // R10 ticks ignored in external mode
        clk_n(40);
        chk(count == 8'd6, "R10 ticks ignored", count, 6);

        // R6 falling edges
        wr_ctl(1, 1, 1, 0);
        clk_n(4);
        wr_cnt(8'h00);
        ext_pin = 1'b1; clk_n(4);
        chk(count == 8'd0, "R6 rising ignored", count, 0);
        ext_pin = 1'b0; clk_n(4);
        chk(count == 8'd1, "R6 falling count", count, 1);

        // R5 external prescaled sweep
        for (int r = 0; r < 3; r++) begin
            wr_ctl(0, 0, 1, r);
            clk_n(4);
            wr_cnt(8'h20);
            for (int i = 0; i < (2 << r) * 3; i++) pulse();
            chk(count == 8'h23, "R5 external ratio", count, 8'h23);
        end

        // R3 write discards partial prescale (1:4)
        wr_ctl(0, 0, 1, 1);
        clk_n(4);
        wr_cnt(8'h00);
        pulse(); pulse();
        wr_cnt(8'h40);
        pulse(); pulse(); pulse();
        chk(count == 8'h40, "R3 partial lost", count, 8'h40);
        pulse();
        chk(count == 8'h41, "R3 full ratio", count, 8'h41);

        // R7/R8 overflow and interrupt
        wr_ctl(1, 0, 1, 0);
        clk_n(4);
        wr_cnt(8'hFE);
        pulse();
        chk(count == 8'hFF && !ovf_flag, "R7 no flag before wrap", {ovf_flag, count}, 8'hFF);
        pulse();
        chk(count == 8'h00 && ovf_flag, "R7 wrap sets flag", {ovf_flag, count}, 9'h100);
        for (int c = 0; c < 4; c++) begin
            irq_en = c[0]; glb_en = c[1];
            clk_n(1);
            chk(irq == (c[0] & c[1]), "R8 irq gating", irq, c[0] & c[1]);
        end
        pulse();
        chk(ovf_flag, "R7 sticky", ovf_flag, 1);
        wr_cnt(8'h00);
        chk(ovf_flag, "R7 sticky over write", ovf_flag, 1);
        ovf_clr = 1'b1; clk_n(1); ovf_clr = 1'b0;
        chk(!ovf_flag && !irq, "R7 clear", {ovf_flag, irq}, 0);
        wr_cnt(8'hFF);
        clk_n(2);
        chk(!ovf_flag, "R7 write no flag", ovf_flag, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule